// File: doc/BRIEF.md
# Burst Flash Memory Controller

This block turns single requests from an internal word-oriented port into access cycles on an external 16-bit NOR flash device. A read can return a byte, a half-word or a word. It can run as a plain asynchronous access, as a page-mode access that keeps the device enabled across beats, or as a synchronous burst timed by a flash clock that the block generates. Writes are asynchronous and always one half-word.

Static configuration inputs set the following:
- the flash clock divider;
- the access time in clocks;
- the shorter access time for later page beats;
- the turnaround gap after each transfer;
- whether address and data share one bus;
- which of two burst address-advance protocols is used.

The requester holds `req_valid` and the request fields stable until `ready` pulses. Configuration changes only while the block is idle.

Top module: `bflash_ctrl`

## Requirements
- R1: While `rst` is high and after it, with no request, `fl_ce_n`, `fl_oe_n`, `fl_we_n` and `fl_adv_n` are 1, and `ready`, `fl_clk` and `fl_ad_oe` are 0.
- R2: `req_size` selects the read width: 0 = byte, 1 = half-word, 2 = word. A half-word read uses half-word address `req_addr>>1`. A byte read returns the upper byte when `req_addr[0]`=1 and the lower byte otherwise, zero-extended. A word read ignores `req_addr[1:0]` and reads half-words 2k and 2k+1 (k = `req_addr>>2`), returning `{hw[2k+1], hw[2k]}`.
- R3: `req_mode` 0 is an asynchronous read. Each beat (1 beat, or 2 for a word) has its own address phase with `fl_adv_n` low, so there is one `fl_adv_n` fall per beat. `ready` rises N*(1+A) clock edges after the accepting edge, where N is the beat count and A = max(`cfg_acc`,1).
- R4: `req_mode` 1 is a page read. It has one address phase. A second beat only steps `fl_addr` and takes P = max(`cfg_pacc`,1) clocks, so `ready` rises 1+A+(N-1)*P edges after acceptance.
- R5: `req_mode[1]`=1 is a synchronous burst. `fl_clk` toggles every `cfg_div`+1 clocks. The address phase lasts until the first rising flash clock edge. Beat j is sampled on rising edge A+j counted from that first one. `ready` rises (`cfg_div`+1)*(1+2*(A+N-1)) edges after acceptance, and `fl_clk` rises A+N times.
- R6: With `cfg_proto`=0 a burst has a single `fl_adv_n` low phase, because the flash clock advances the address. With `cfg_proto`=1, `fl_adv_n` is also driven low for the flash clock period before each later beat, giving one fall per beat.
- R7: A write stores `req_wdata` at half-word address `req_addr>>1`, ignoring `req_size` and `req_mode`. `fl_we_n` is low for A clocks after a one-clock address phase, and `ready` rises 1+A edges after acceptance. `fl_we_n` and `fl_oe_n` are never low together.
- R8: With `cfg_mux`=1, whenever `fl_adv_n` is low outside a data phase, `fl_ad_oe` is 1 and `fl_ad_o` carries the half-word address. With `cfg_mux`=0, `fl_ad_oe` is never 1 while `fl_oe_n` is low.
- R9: After `ready`, `fl_ce_n` stays high for `cfg_turn`+1 clocks before the next access can start. A request held valid across `ready` therefore drops `fl_ce_n` `cfg_turn`+2 edges after the `ready` edge.
- R10: `ready` is a single-cycle pulse, and `rdata` is valid in that cycle.
- R11: An access time of 0 in `cfg_acc` or `cfg_pacc` behaves exactly as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = half-word write, 0 = read |
| req_mode | input | 2 | Read mode: 0 async, 1 page, 2 or 3 burst |
| req_size | input | 2 | Read size: 0 byte, 1 half-word, 2 word |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid with ready |
| cfg_div | input | DIVW | Flash clock divider |
| cfg_acc | input | CW | Access time in clocks (burst: flash clocks) |
| cfg_pacc | input | CW | Later page beat access time |
| cfg_turn | input | CW | Turnaround gap after a transfer |
| cfg_mux | input | 1 | 1 = address and data multiplexed |
| cfg_proto | input | 1 | Burst advance: 0 by clock, 1 by advance strobe |
| fl_clk | output | 1 | Flash clock, low outside bursts |
| fl_adv_n | output | 1 | Address valid / advance strobe, active low |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_addr | output | AW-1 | Half-word address |
| fl_ad_o | output | 16 | Address/data bus output value |
| fl_ad_oe | output | 1 | Bus output enable |
| fl_ad_i | input | 16 | Data bus input |

## Verification
The bench goes after the latencies of every mode for access times of zero and non-zero and for several divider settings. A controller that miscounted its wait or treated zero as a literal zero would move `ready` by one or more cycles and sample the bus before the device drives it. It checks word reads for half-word order and byte reads for lane choice, so a swapped assembly returns the halves reversed or the wrong byte. It counts address strobes and flash clock edges per burst under both advance protocols, and it holds a request across `ready` to measure the turnaround gap, which a design that re-entered idle too early would cut short.

// File: rtl/bflash_pkg.sv
package bflash_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AADR,
    ST_AWAIT,
    ST_BADR,
    ST_BWAIT,
    ST_WADR,
    ST_WPULSE,
    ST_TURN
  } bf_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/bflash_clkdiv.sv
module bflash_clkdiv #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            fl_clk,
  output logic            rise
);
  logic [DIVW-1:0] dcnt;
  logic            tick;

  assign tick = run && (dcnt == div);
  assign rise = tick && !fl_clk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      dcnt   <= '0;
      fl_clk <= 1'b0;
    end else if (tick) begin
      dcnt   <= '0;
      fl_clk <= ~fl_clk;
    end else begin
      dcnt   <= dcnt + 1'b1;
    end
  end

  // R5
  clk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> (!run || $stable(fl_clk)));

  // R1
  clk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> !fl_clk);

endmodule

// File: rtl/bflash_rdasm.sv
module bflash_rdasm #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp,
  input  logic          last,
  input  logic [1:0]    size,
  input  logic          lane,
  input  logic [DW-1:0] din,
  output logic [2*DW-1:0] rdata
);
  localparam int BW = DW / 2;

  logic [DW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      rdata <= '0;
    end else if (samp) begin
      if (!last) begin
        lo_q <= din;
      end else if (size[1]) begin
        rdata <= {din, lo_q};
      end else if (size[0]) begin
        rdata <= {{DW{1'b0}}, din};
      end else begin
        rdata <= {{(2*DW-BW){1'b0}}, (lane ? din[DW-1:BW] : din[BW-1:0])};
      end
    end
  end

endmodule

// File: rtl/bflash_fsm.sv
module bflash_fsm
  import bflash_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_mode,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [CW-1:0] cfg_acc,
  input  logic [CW-1:0] cfg_pacc,
  input  logic [CW-1:0] cfg_turn,
  input  logic          cfg_mux,
  input  logic          cfg_proto,
  input  logic          rise,
  output logic          run,
  output logic          samp,
  output logic          last,
  output logic [1:0]    size_q,
  output logic          lane,
  output logic          ready,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic          fl_adv_n,
  output logic [AW-2:0] fl_addr,
  output logic [DW-1:0] fl_ad_o,
  output logic          fl_ad_oe
);
  localparam int FAW = AW - 1;
  localparam int AL  = (FAW < DW) ? FAW : DW;

  bf_state_e      st, st_n;
  logic [CW-1:0]  cnt, cnt_n, acc1, pacc1;
  logic [FAW-1:0] hwa, hwa_n;
  logic           beat, beat_n;
  logic [1:0]     size_n, mode_q, mode_n;
  logic           lane_n;
  logic [DW-1:0]  wd, wd_n;
  logic           rdy_n, adr_n, wr_n;

  function automatic logic [DW-1:0] bus_addr(input logic [FAW-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    r[AL-1:0] = a[AL-1:0];
    return r;
  endfunction

  assign acc1  = (cfg_acc  == '0) ? CW'(1) : cfg_acc;
  assign pacc1 = (cfg_pacc == '0) ? CW'(1) : cfg_pacc;
  assign run   = (st == ST_BADR) || (st == ST_BWAIT);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    hwa_n  = hwa;
    beat_n = beat;
    size_n = size_q;
    mode_n = mode_q;
    lane_n = lane;
    wd_n   = wd;
    samp   = 1'b0;
    last   = 1'b0;
    rdy_n  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_valid) begin
          size_n = req_size;
          mode_n = req_mode;
          lane_n = req_addr[0];
          wd_n   = req_wdata;
          beat_n = 1'b0;
          if (req_write) begin
            hwa_n = req_addr[AW-1:1];
            st_n  = ST_WADR;
          end else begin
            hwa_n = req_size[1] ? {req_addr[AW-1:2], 1'b0} : req_addr[AW-1:1];
            st_n  = req_mode[1] ? ST_BADR : ST_AADR;
          end
        end
      end
      ST_AADR: begin
        st_n  = ST_AWAIT;
        cnt_n = acc1;
      end
      ST_AWAIT: begin
        if (cnt == CW'(1)) begin
          samp = 1'b1;
          if (beat == size_q[1]) begin
            last  = 1'b1;
            rdy_n = 1'b1;
            st_n  = ST_TURN;
            cnt_n = cfg_turn;
          end else begin
            beat_n = 1'b1;
            hwa_n  = hwa + 1'b1;
            if (mode_q[0]) cnt_n = pacc1;
            else           st_n  = ST_AADR;
          end
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_BADR: begin
        if (rise) begin
          st_n  = ST_BWAIT;
          cnt_n = acc1;
        end
      end
      ST_BWAIT: begin
        if (rise) begin
          if (cnt == CW'(1)) begin
            samp = 1'b1;
            if (beat == size_q[1]) begin
              last  = 1'b1;
              rdy_n = 1'b1;
              st_n  = ST_TURN;
              cnt_n = cfg_turn;
            end else begin
              beat_n = 1'b1;
              hwa_n  = hwa + 1'b1;
            end
          end else begin
            cnt_n = cnt - 1'b1;
          end
        end
      end
      ST_WADR: begin
        st_n  = ST_WPULSE;
        cnt_n = acc1;
      end
      ST_WPULSE: begin
        if (cnt == CW'(1)) begin
          rdy_n = 1'b1;
          st_n  = ST_TURN;
          cnt_n = cfg_turn;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt == '0) st_n = ST_IDLE;
        else           cnt_n = cnt - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign adr_n = (st_n == ST_AADR) || (st_n == ST_BADR) || (st_n == ST_WADR);
  assign wr_n  = (st_n == ST_WADR) || (st_n == ST_WPULSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      hwa      <= '0;
      beat     <= 1'b0;
      size_q   <= '0;
      mode_q   <= '0;
      lane     <= 1'b0;
      wd       <= '0;
      ready    <= 1'b0;
      fl_ce_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fl_adv_n <= 1'b1;
      fl_addr  <= '0;
      fl_ad_o  <= '0;
      fl_ad_oe <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      hwa      <= hwa_n;
      beat     <= beat_n;
      size_q   <= size_n;
      mode_q   <= mode_n;
      lane     <= lane_n;
      wd       <= wd_n;
      ready    <= rdy_n;
      fl_ce_n  <= (st_n == ST_IDLE) || (st_n == ST_TURN);
      fl_oe_n  <= !((st_n == ST_AWAIT) || (st_n == ST_BWAIT));
      fl_we_n  <= (st_n != ST_WPULSE);
      fl_adv_n <= !(adr_n || ((st_n == ST_BWAIT) && cfg_proto && beat_n));
      fl_addr  <= hwa_n;
      fl_ad_oe <= (cfg_mux && adr_n) || wr_n;
      if (cfg_mux && adr_n) fl_ad_o <= bus_addr(hwa_n);
      else if (wr_n)        fl_ad_o <= wd_n;
    end
  end

  // R7
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));

  // R10
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  // R9
  turn_ce_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> fl_ce_n);

  // R8
  sep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mux && !fl_oe_n) |-> !fl_ad_oe);

  // R8
  mux_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_mux && !fl_adv_n && fl_oe_n) |-> (fl_ad_oe && fl_ad_o == bus_addr(fl_addr)));

  // R6
  adv_clkproto_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_proto && !fl_oe_n) |-> fl_adv_n);

endmodule

// File: rtl/bflash_ctrl.sv
module bflash_ctrl #(
  parameter int AW   = 24,
  parameter int CW   = 4,
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_mode,
  input  logic [1:0]      req_size,
  input  logic [AW-1:0]   req_addr,
  input  logic [15:0]     req_wdata,
  output logic            ready,
  output logic [31:0]     rdata,
  input  logic [DIVW-1:0] cfg_div,
  input  logic [CW-1:0]   cfg_acc,
  input  logic [CW-1:0]   cfg_pacc,
  input  logic [CW-1:0]   cfg_turn,
  input  logic            cfg_mux,
  input  logic            cfg_proto,
  output logic            fl_clk,
  output logic            fl_adv_n,
  output logic            fl_ce_n,
  output logic            fl_oe_n,
  output logic            fl_we_n,
  output logic [AW-2:0]   fl_addr,
  output logic [15:0]     fl_ad_o,
  output logic            fl_ad_oe,
  input  logic [15:0]     fl_ad_i
);
  localparam int DW = 16;

  logic       run, rise, samp, last, lane;
  logic [1:0] size_q;

  bflash_clkdiv #(.DIVW(DIVW)) u_clkdiv (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .div    (cfg_div),
    .fl_clk (fl_clk),
    .rise   (rise)
  );

  bflash_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mode  (req_mode),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cfg_acc   (cfg_acc),
    .cfg_pacc  (cfg_pacc),
    .cfg_turn  (cfg_turn),
    .cfg_mux   (cfg_mux),
    .cfg_proto (cfg_proto),
    .rise      (rise),
    .run       (run),
    .samp      (samp),
    .last      (last),
    .size_q    (size_q),
    .lane      (lane),
    .ready     (ready),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n),
    .fl_adv_n  (fl_adv_n),
    .fl_addr   (fl_addr),
    .fl_ad_o   (fl_ad_o),
    .fl_ad_oe  (fl_ad_oe)
  );

  bflash_rdasm #(.DW(DW)) u_rdasm (
    .clk   (clk),
    .rst   (rst),
    .samp  (samp),
    .last  (last),
    .size  (size_q),
    .lane  (lane),
    .din   (fl_ad_i),
    .rdata (rdata)
  );

endmodule

// File: tb/bflash_ctrl_bench.sv
module bflash_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int NHW = 1 << (AW - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_mode = '0, req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic ready;
  logic [31:0] rdata;
  logic [3:0] cfg_div = '0, cfg_acc = 4'd1, cfg_pacc = 4'd1, cfg_turn = '0;
  logic cfg_mux = 1'b0, cfg_proto = 1'b0;
  logic fl_clk, fl_adv_n, fl_ce_n, fl_oe_n, fl_we_n, fl_ad_oe;
  logic [AW-2:0] fl_addr;
  logic [15:0] fl_ad_o, fl_ad_i;

  logic [15:0] fmem [NHW];
  logic [15:0] ref_mem [NHW];
  int nchk = 0, nerr = 0;
  int advf = 0, clkr = 0, muxerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bflash_ctrl #(.AW(AW), .CW(4), .DIVW(4)) u_bflash_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mode(req_mode), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rdata(rdata), .cfg_div(cfg_div),
    .cfg_acc(cfg_acc), .cfg_pacc(cfg_pacc), .cfg_turn(cfg_turn),
    .cfg_mux(cfg_mux), .cfg_proto(cfg_proto), .fl_clk(fl_clk),
    .fl_adv_n(fl_adv_n), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_ad_o(fl_ad_o),
    .fl_ad_oe(fl_ad_oe), .fl_ad_i(fl_ad_i)
  );

  // device model
  assign fl_ad_i = (!fl_ce_n && !fl_oe_n) ? fmem[fl_addr] : 16'hFFFF;
  always @(posedge fl_we_n) if (!rst) fmem[fl_addr] <= fl_ad_o;
  always @(negedge fl_adv_n) if (!rst) advf++;
  always @(posedge fl_clk) if (!rst) clkr++;
  always @(negedge clk) if (!rst) begin
    if (cfg_mux && !fl_adv_n && fl_oe_n && !fl_ce_n &&
        !(fl_ad_oe && fl_ad_o == {7'd0, fl_addr})) muxerr++;
    if (!cfg_mux && !fl_oe_n && fl_ad_oe) muxerr++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a, input logic [1:0] sz);
    logic [AW-2:0] h;
    logic [AW-2:0] b;
    h = a[AW-1:1];
    b = {a[AW-1:2], 1'b0};
    if (sz[1]) return {ref_mem[b + 1'b1], ref_mem[b]};
    if (sz[0]) return {16'd0, ref_mem[h]};
    return {24'd0, (a[0] ? ref_mem[h][15:8] : ref_mem[h][7:0])};
  endfunction

  function automatic int exp_lat(input logic wr, input logic [1:0] md, input int nb);
    int a, p;
    a = (cfg_acc == 0) ? 1 : int'(cfg_acc);
    p = (cfg_pacc == 0) ? 1 : int'(cfg_pacc);
    if (wr) return 1 + a;
    if (md[1]) return (int'(cfg_div) + 1) * (1 + 2 * (a + nb - 1));
    if (md == 2'd1) return 1 + a + (nb - 1) * p;
    return nb * (1 + a);
  endfunction

  task automatic do_op(input logic wr, input logic [1:0] md, input logic [1:0] sz,
                       input logic [AW-1:0] a, input logic [15:0] wd);
    int nb, lat, n, a1, expadv;
    logic [31:0] exd;
    nb  = (!wr && sz[1]) ? 2 : 1;
    lat = exp_lat(wr, md, nb);
    a1  = (cfg_acc == 0) ? 1 : int'(cfg_acc);
    exd = exp_rd(a, sz);
    expadv = wr ? 1 : md[1] ? (cfg_proto ? nb : 1) : (md == 2'd1) ? 1 : nb;
    advf = 0; clkr = 0; muxerr = 0;
    req_write = wr; req_mode = md; req_size = sz; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!ready && n < 400);
    // R3 R4 R5 R7 R11: latency
    chk(wr ? "R7 latency" : md[1] ? "R5 latency" : md == 2'd1 ? "R4 latency" : "R3 latency",
        n, lat + 1);
    if (!wr) chk("R2 read data", rdata, exd);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 ready pulse", {31'd0, ready}, 32'd0);
    chk(md[1] && !wr ? "R6 adv strobes" : "R3 adv strobes", advf, expadv);
    if (md[1] && !wr) chk("R5 flash clock rises", clkr, a1 + nb);
    chk("R8 bus drive", muxerr, 0);
    if (wr) begin
      ref_mem[a[AW-1:1]] = wd;
      chk("R7 device write", {16'd0, fmem[a[AW-1:1]]}, {16'd0, wd});
    end
    repeat (int'(cfg_turn) + 2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int seed, m;
    seed = $urandom(32'h1BF1);
    for (int i = 0; i < NHW; i++) begin
      fmem[i] = 16'(i * 16'h9E37) ^ 16'h5A5A;
      ref_mem[i] = fmem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {fl_ce_n, fl_oe_n, fl_we_n, fl_adv_n, ready, fl_clk, fl_ad_oe},
        7'b1111000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle outputs", {fl_ce_n, fl_oe_n, fl_we_n, fl_adv_n, ready, fl_clk, fl_ad_oe},
        7'b1111000);

    // directed: R2 sizes, R11 zero access time
    cfg_acc = 4'd2;
    do_op(1'b0, 2'd0, 2'd2, 10'h047, 16'h0);
    do_op(1'b0, 2'd0, 2'd0, 10'h031, 16'h0);
    do_op(1'b0, 2'd0, 2'd0, 10'h030, 16'h0);
    do_op(1'b0, 2'd0, 2'd1, 10'h031, 16'h0);
    cfg_acc = 4'd0; cfg_pacc = 4'd0;
    do_op(1'b0, 2'd1, 2'd2, 10'h100, 16'h0);      // R11
    do_op(1'b1, 2'd2, 2'd2, 10'h101, 16'hBEEF);   // R7 size/mode ignored
    do_op(1'b0, 2'd0, 2'd1, 10'h100, 16'h0);
    cfg_mux = 1'b1; cfg_proto = 1'b1; cfg_div = 4'd2; cfg_acc = 4'd3;
    do_op(1'b0, 2'd2, 2'd2, 10'h200, 16'h0);      // R6 advance strobe protocol
    cfg_proto = 1'b0;
    do_op(1'b0, 2'd2, 2'd2, 10'h200, 16'h0);      // R6 clock advance
    do_op(1'b1, 2'd0, 2'd1, 10'h202, 16'h1234);   // R8 multiplexed write
    do_op(1'b0, 2'd1, 2'd2, 10'h200, 16'h0);

    // R9 turnaround with request held across ready
    cfg_turn = 4'd3; cfg_mux = 1'b0;
    req_write = 1'b0; req_mode = 2'd0; req_size = 2'd1; req_addr = 10'h010;
    req_valid = 1'b1;
    do @(negedge clk); while (!ready);
    m = 0;
    do begin @(negedge clk); m++; end while (fl_ce_n && m < 50);
    chk("R9 turnaround gap", m, int'(cfg_turn) + 2);
    do @(negedge clk); while (!ready);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);

    // random mix
    for (int i = 0; i < 150; i++) begin
      cfg_div = 4'($urandom % 4); cfg_acc = 4'($urandom % 6);
      cfg_pacc = 4'($urandom % 4); cfg_turn = 4'($urandom % 4);
      cfg_mux = 1'($urandom % 2); cfg_proto = 1'($urandom % 2);
      do_op(($urandom % 4) == 0, 2'($urandom % 4), 2'($urandom % 3),
            AW'($urandom), 16'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule